// File: doc/BRIEF.md
# Bit-Parallel Shift-Or Pattern Matcher

This block scans a stream of symbols for a single fixed pattern of M symbols. Software loads a table with one M-bit mask per symbol value. In each mask, a cleared bit marks a pattern position that holds that symbol.

The block keeps an M-bit state vector. For each accepted symbol, the vector moves up by one bit, a zero enters at the bottom, and the result is ORed with the symbol's mask. A zero in the top bit means every pattern position has lined up with the recent input, so the pattern has just ended.

The stream side uses a valid/ready handshake and accepts at most one symbol per cycle. A synchronous clear returns the search to its starting point. The table write port works only while the stream is idle.

Top module: `smatch_top`

## Requirements
- R1: After reset the state vector is all ones, `match` is low and `sym_ready` is high.
- R2: A table write (`tbl_we` high while `sym_valid` is low) stores `tbl_data` as the mask of symbol `tbl_addr`. Bit i of the mask is 0 exactly when pattern position i (position 0 is the first pattern symbol) equals that symbol.
- R3: Every table entry that has never been written reads all ones, so such a symbol ends any partial match in progress.
- R4: For each accepted symbol, the next state is the current state shifted one bit toward bit M-1, with 0 entering bit 0, ORed with that symbol's mask.
- R5: `match` is high in the cycle after a symbol is accepted exactly when bit M-1 of the updated state is 0. With the pattern ababc, the stream abdababc gives exactly one match, on the final symbol.
- R6: `match` is a single-cycle pulse. It is low after any cycle in which no symbol was accepted.
- R7: Overlapping occurrences are each reported. With pattern aaaaa, seven a symbols give matches on the fifth, sixth and seventh.
- R8: A table write presented while `sym_valid` is high is ignored, and the table keeps its previous contents.
- R9: While `srch_clr` is high, `sym_ready` is low, no symbol is accepted and the state returns to all ones, so a partial match made before the clear cannot complete after it.
- R10: A symbol is taken only when `sym_valid` and `sym_ready` are both high. Otherwise the state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| srch_clr | input | 1 | Synchronous search restart |
| tbl_we | input | 1 | Mask table write strobe |
| tbl_addr | input | SYM_W | Symbol whose mask is written |
| tbl_data | input | M | Mask value to store |
| sym_valid | input | 1 | Input symbol present |
| sym_ready | output | 1 | Block can take a symbol |
| sym_data | input | SYM_W | Input symbol |
| match | output | 1 | Pattern ended at the last accepted symbol |

## Verification
The bench builds the block with M=5 and SYM_W=8. This allows the five-symbol example pattern and its mask vectors to be loaded directly, so characters such as x can be used as symbols absent from the table. A five-bit state is short enough that a pattern of repeated a symbols reaches the overlapping-match case within a few cycles. The bench also covers table writes blocked by a live stream, clearing the search partway through a partial match, and idle cycles between symbols.

// File: rtl/smatch_pkg.sv
package smatch_pkg;

  // Shift-or step: move partial matches toward the top bit (zero enters
  // at bit 0), then knock out positions the symbol does not satisfy.
  function automatic logic [31:0] so_step(input logic [31:0] st,
                                          input logic [31:0] msk,
                                          input int unsigned m);
    logic [31:0] keep;
    keep = (m >= 32) ? 32'hFFFF_FFFF : ((32'd1 << m) - 32'd1);
    return ((st << 1) | msk) & keep;
  endfunction

  // Match test: top state bit cleared means the full pattern lined up.
  function automatic logic so_hit(input logic [31:0] st,
                                  input int unsigned m);
    return ~st[m-1];
  endfunction

endpackage

// File: rtl/smatch_mask_tbl.sv
module smatch_mask_tbl #(
  parameter int SYM_W = 8,
  parameter int M     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SYM_W-1:0] wr_addr,
  input  logic [M-1:0]     wr_mask,
  input  logic [SYM_W-1:0] rd_addr,
  output logic [M-1:0]     rd_mask
);
  localparam int DEPTH = 1 << SYM_W;

  logic [M-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_mask;
    end
  end

  assign rd_mask = mem_q[rd_addr];
endmodule

// File: rtl/smatch_state.sv
module smatch_state
  import smatch_pkg::*;
#(
  parameter int M = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [M-1:0] mask,
  output logic [M-1:0] st_q,
  output logic         hit_q
);
  logic [31:0] st_ext, msk_ext, nxt_ext;
  logic [M-1:0] st_nxt;

  always_comb begin
    st_ext  = '0;
    msk_ext = '0;
    st_ext[M-1:0]  = st_q;
    msk_ext[M-1:0] = mask;
    nxt_ext = so_step(st_ext, msk_ext, M);
    st_nxt  = nxt_ext[M-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '1;
      hit_q <= 1'b0;
    end else if (clr) begin
      st_q  <= '1;
      hit_q <= 1'b0;
    end else if (step) begin
      st_q  <= st_nxt;
      hit_q <= so_hit(nxt_ext, M);
    end else begin
      hit_q <= 1'b0;
    end
  end
endmodule

// File: rtl/smatch_top.sv
module smatch_top #(
  parameter int SYM_W = 8,
  parameter int M     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srch_clr,
  input  logic             tbl_we,
  input  logic [SYM_W-1:0] tbl_addr,
  input  logic [M-1:0]     tbl_data,
  input  logic             sym_valid,
  output logic             sym_ready,
  input  logic [SYM_W-1:0] sym_data,
  output logic             match
);
  logic         accept;
  logic         tbl_wr_ok;
  logic [M-1:0] rd_mask;
  logic [M-1:0] st_q;

  assign sym_ready = ~srch_clr;
  assign accept    = sym_valid & sym_ready;
  assign tbl_wr_ok = tbl_we & ~sym_valid;

  smatch_mask_tbl #(.SYM_W(SYM_W), .M(M)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_wr_ok),
    .wr_addr (tbl_addr),
    .wr_mask (tbl_data),
    .rd_addr (sym_data),
    .rd_mask (rd_mask)
  );

  smatch_state #(.M(M)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (srch_clr),
    .step  (accept),
    .mask  (rd_mask),
    .st_q  (st_q),
    .hit_q (match)
  );
endmodule

// File: rtl/smatch_chk.sv
module smatch_chk #(
  parameter int M = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         srch_clr,
  input logic         accept,
  input logic [M-1:0] st_q,
  input logic [M-1:0] rd_mask,
  input logic         match
);
  a_r9_clear_restores_ones: assert property (@(posedge clk) disable iff (!rst_n)
    srch_clr |=> st_q == {M{1'b1}});

  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !srch_clr) |=> $stable(st_q));

  a_r4_shift_or_update: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !srch_clr) |=> st_q == (($past(st_q) << 1) | $past(rd_mask)));

  a_r5_match_from_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !srch_clr) |=> match == ~st_q[M-1]);

  a_r6_no_match_without_symbol: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !match);
endmodule

bind smatch_top smatch_chk #(.M(M)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .srch_clr (srch_clr),
  .accept   (accept),
  .st_q     (st_q),
  .rd_mask  (rd_mask),
  .match    (match)
);

// File: tb/smatch_top_tb.sv
module smatch_top_tb;
  localparam int SYM_W = 8;
  localparam int M     = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             srch_clr = 1'b0;
  logic             tbl_we = 1'b0;
  logic [SYM_W-1:0] tbl_addr = '0;
  logic [M-1:0]     tbl_data = '0;
  logic             sym_valid = 1'b0;
  logic             sym_ready;
  logic [SYM_W-1:0] sym_data = '0;
  logic             match;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  byte pat [M];
  byte hist [$];

  always #10 clk = ~clk;

  smatch_top #(.SYM_W(SYM_W), .M(M)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit model_hit();
    if (hist.size() != M) return 0;
    for (int i = 0; i < M; i++) if (hist[i] != pat[i]) return 0;
    return 1;
  endfunction

  // One cycle: drive at negedge, check ready, clock, check match.
  task automatic step(input bit v, input byte s, input bit clr,
                      input bit we, input byte wa, input logic [M-1:0] wd,
                      input string req);
    bit exp_m;
    sym_valid = v; sym_data = s; srch_clr = clr;
    tbl_we = we; tbl_addr = wa; tbl_data = wd;
    #1;
    chk(sym_ready == !clr, "R9/R10 ready", sym_ready, !clr);
    if (clr) begin
      hist.delete();
      exp_m = 0;
    end else if (v) begin
      hist.push_back(s);
      if (hist.size() > M) void'(hist.pop_front());
      exp_m = model_hit();
    end else begin
      exp_m = 0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(match == exp_m, req, match, exp_m);
  endtask

  task automatic feed(input string txt, input string req);
    for (int i = 0; i < txt.len(); i++) step(1, txt[i], 0, 0, 0, '0, req);
  endtask

  task automatic wr(input byte a, input logic [M-1:0] d);
    step(0, 0, 0, 1, a, d, "R2 write");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(match == 0, "R1 match low", match, 0);
    chk(sym_ready == 1, "R1 ready high", sym_ready, 1);

    // R2: example masks, bit i = pattern position i
    wr("a", 5'b11010); wr("b", 5'b10101); wr("c", 5'b01111); wr("d", 5'b11111);
    pat = '{"a", "b", "a", "b", "c"};
    hist.delete();

    feed("abdababc", "R5 example text");
    step(0, "c", 0, 0, 0, '0, "R6 idle no match");
    feed("ababxc", "R3 absent symbol breaks");
    feed("abxababc", "R3 recover after absent");

    // R8: write x as if it were c while the stream is live
    step(1, "a", 0, 1, "x", 5'b01111, "R8 write during stream");
    feed("babx", "R8 write ignored");
    feed("ababx", "R8 x still absent");

    // R10: a gap with valid low holds the partial match
    feed("abab", "R10 prefix");
    step(0, "c", 0, 0, 0, '0, "R10 not taken");
    step(1, "c", 0, 0, 0, '0, "R10 completes after gap");

    // R9: clear drops the partial match and blocks the symbol
    feed("abab", "R9 prefix");
    step(1, "c", 1, 0, 0, '0, "R9 clear cycle");
    step(1, "c", 0, 0, 0, '0, "R9 no match after clear");
    feed("ababc", "R9 search resumes");

    // R7: overlapping occurrences
    wr("a", 5'b00000); wr("b", 5'b11111); wr("c", 5'b11111);
    pat = '{"a", "a", "a", "a", "a"};
    hist.delete();
    feed("aaaaaaa", "R7 overlap");
    feed("aabaaaaa", "R7 break and overlap");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule